// File: doc/BRIEF.md
# Triple-Redundant Instruction Store with Background Scrub

This block supplies instruction words to a small processor from three identical copies of the program. Every copy is a dual-port memory. The fetch port of each copy is read on every clock. A bitwise majority of the three words is registered onto the instruction output, so a corrupted bit in any single copy never reaches the core.

The second port of every copy belongs to a scrub engine. It visits one location per two clocks. In the first clock it reads the location from all three copies. In the second clock it writes the majority word back into all three. Without this rewrite, flipped bits would pile up until two copies disagree with the third at the same bit. The scrub engine is itself triplicated. There are three state replicas, each with its own address counter, its own phase bit and its own write enable. Each replica takes the majority of the three counters and of the three phase bits as its current state, so a single disturbed register falls back into step at the next clock. A scrub write is held back whenever its address equals the fetch address in that cycle.

The program image is placed in the memories at initialization and is not reloaded by reset. For verification, a fault injection input inverts one chosen bit of one chosen copy.

Top module: `tmr_irom_scrub`

## Requirements
- R1: The program word at address a is the low DATA_W bits of (a * 0x9E37) XOR 0x5A3C. A fetch address presented before clock edge k appears on `instr_out` after edge k+1, a two-clock latency. Fetch traffic never changes the stored program.
- R2: While `rst` is high, `instr_out` is cleared to zero at each clock edge.
- R3: A bit inverted in only one of the three copies does not change `instr_out` for any address.
- R4: After one copy has been disturbed, one full scrub pass restores that copy from the majority. A later disturbance of the same bit in a different copy then still yields the correct word.
- R5: The scrub phase alternates on every clock. A scrub write can occur only in the write phase, so one location is handled per two clocks.
- R6: The three scrub address counters are equal at every clock edge outside reset. Each replica loads its next value from the majority of all three.
- R7: A scrub write never targets the address on `fetch_addr` in the same cycle. In that case the write is skipped and the counter holds, so that location is retried at the next step.
- R8: The scrub address advances by one per completed write, wraps from the last location to zero, and runs without stopping after reset. The last and first locations are both scrubbed.
- R9: When `inj_en` is high at a clock edge, bit `inj_bit` of word `inj_addr` in copy `inj_copy` is inverted. Copy codes are 0, 1 and 2; code 3 touches no copy.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Memory and scrub clock |
| rst | input | 1 | Synchronous active-high reset |
| fetch_addr | input | ADDR_W | Instruction fetch address |
| instr_out | output | DATA_W | Registered majority-voted instruction |
| inj_en | input | 1 | Fault injection strobe |
| inj_copy | input | 2 | Copy to disturb (0..2, 3 = none) |
| inj_addr | input | ADDR_W | Word to disturb |
| inj_bit | input | BIT_W | Bit position to invert |

## Verification
The bench corrupts one copy and then, after a full pass, corrupts a different copy at the same bit and address. A design that does not scrub, or that writes back an unvoted word, then outputs a wrong instruction. It does the same at the last and the first address, to catch a counter that fails to wrap or skips an end location. It parks the fetch address on one location and corrupts two copies there one after the other. A design that ignored the address clash would repair the first corruption, while a correct one must show the corrupted word. Single-copy upsets are checked on every address, and the unused copy code 3 is checked, to catch a voter that passes a single copy through or a decode that aliases that code onto a real copy.

// File: rtl/tmr_irom_pkg.sv
package tmr_irom_pkg;

  // Generated program contents; callers truncate to their word width.
  function automatic logic [31:0] img_word(input int unsigned a);
    return (32'(a) * 32'h0000_9E37) ^ 32'h0000_5A3C;
  endfunction

endpackage

// File: rtl/tmr_irom_voter.sv
module tmr_irom_voter #(
  parameter int W = 8
) (
  input  logic [W-1:0] a,
  input  logic [W-1:0] b,
  input  logic [W-1:0] c,
  output logic [W-1:0] y
);
  assign y = (a & b) | (a & c) | (b & c);
endmodule

// File: rtl/tmr_irom_bank.sv
module tmr_irom_bank import tmr_irom_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int BIT_W  = 4
) (
  input  logic              clk,
  // fetch port (read-only in use)
  input  logic [ADDR_W-1:0] addr_a,
  input  logic              we_a,
  input  logic [DATA_W-1:0] din_a,
  output logic [DATA_W-1:0] rd_a,
  // scrub port
  input  logic [ADDR_W-1:0] addr_b,
  input  logic              we_b,
  input  logic [DATA_W-1:0] din_b,
  output logic [DATA_W-1:0] rd_b,
  // fault injection
  input  logic              inj_en,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [BIT_W-1:0]  inj_bit
);
  localparam int DEPTH = 1 << ADDR_W;

  logic [DATA_W-1:0] mem [DEPTH];

  initial begin
    for (int i = 0; i < DEPTH; i++) mem[i] = DATA_W'(img_word(i));
  end

  always_ff @(posedge clk) begin
    if (we_a) mem[addr_a] <= din_a;
    if (inj_en)
      mem[inj_addr] <= mem[inj_addr] ^ (DATA_W'(1) << inj_bit);
    else if (we_b)
      mem[addr_b] <= din_b;
    rd_a <= mem[addr_a];
    rd_b <= mem[addr_b];
  end
endmodule

// File: rtl/tmr_irom_scrub_fsm.sv
module tmr_irom_scrub_fsm #(
  parameter int ADDR_W = 6
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] cnt_v,
  input  logic              ph_v,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [ADDR_W-1:0] cnt_q,
  output logic              ph_q,
  output logic              we
);
  logic hit;

  // phase 0: read location; phase 1: write voted word back
  assign hit = (cnt_v == fetch_addr);
  assign we  = ph_v & ~hit;

  always_ff @(posedge clk) begin
    if (rst) begin
      cnt_q <= '0;
      ph_q  <= 1'b0;
    end else begin
      ph_q  <= ~ph_v;
      cnt_q <= we ? cnt_v + 1'b1 : cnt_v;
    end
  end
endmodule

// File: rtl/tmr_irom_scrub.sv
module tmr_irom_scrub import tmr_irom_pkg::*; #(
  parameter int ADDR_W = 6,
  parameter int DATA_W = 16,
  parameter int BIT_W  = $clog2(DATA_W)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic [ADDR_W-1:0] fetch_addr,
  output logic [DATA_W-1:0] instr_out,
  input  logic              inj_en,
  input  logic [1:0]        inj_copy,
  input  logic [ADDR_W-1:0] inj_addr,
  input  logic [BIT_W-1:0]  inj_bit
);
  localparam int COPIES = 3;

  logic [COPIES-1:0][DATA_W-1:0] rd_a;
  logic [COPIES-1:0][DATA_W-1:0] rd_b;
  logic [COPIES-1:0][DATA_W-1:0] wb_v;
  logic [COPIES-1:0][ADDR_W-1:0] cnt_q;
  logic [COPIES-1:0][ADDR_W-1:0] cnt_v;
  logic [COPIES-1:0]             ph_q;
  logic [COPIES-1:0]             ph_v;
  logic [COPIES-1:0]             scrub_we;
  logic [DATA_W-1:0]             fetch_v;
  logic [DATA_W-1:0]             instr_q;

  for (genvar i = 0; i < COPIES; i++) begin : g_copy
    tmr_irom_voter #(.W(ADDR_W)) u_cnt_vote (
      .a(cnt_q[0]), .b(cnt_q[1]), .c(cnt_q[2]), .y(cnt_v[i]));
    tmr_irom_voter #(.W(1)) u_ph_vote (
      .a(ph_q[0]), .b(ph_q[1]), .c(ph_q[2]), .y(ph_v[i]));
    tmr_irom_voter #(.W(DATA_W)) u_wb_vote (
      .a(rd_b[0]), .b(rd_b[1]), .c(rd_b[2]), .y(wb_v[i]));

    tmr_irom_scrub_fsm #(.ADDR_W(ADDR_W)) u_fsm (
      .clk        (clk),
      .rst        (rst),
      .cnt_v      (cnt_v[i]),
      .ph_v       (ph_v[i]),
      .fetch_addr (fetch_addr),
      .cnt_q      (cnt_q[i]),
      .ph_q       (ph_q[i]),
      .we         (scrub_we[i])
    );

    tmr_irom_bank #(.ADDR_W(ADDR_W), .DATA_W(DATA_W), .BIT_W(BIT_W)) u_bank (
      .clk      (clk),
      .addr_a   (fetch_addr),
      .we_a     (1'b0),
      .din_a    ('0),
      .rd_a     (rd_a[i]),
      .addr_b   (cnt_v[i]),
      .we_b     (scrub_we[i]),
      .din_b    (wb_v[i]),
      .rd_b     (rd_b[i]),
      .inj_en   (inj_en && (inj_copy == 2'(i))),
      .inj_addr (inj_addr),
      .inj_bit  (inj_bit)
    );
  end

  tmr_irom_voter #(.W(DATA_W)) u_fetch_vote (
    .a(rd_a[0]), .b(rd_a[1]), .c(rd_a[2]), .y(fetch_v));

  always_ff @(posedge clk) begin
    if (rst) instr_q <= '0;
    else     instr_q <= fetch_v;
  end

  assign instr_out = instr_q;
endmodule

// File: rtl/tmr_irom_scrub_chk.sv
module tmr_irom_scrub_chk #(
  parameter int ADDR_W = 6
) (
  input logic                   clk,
  input logic                   rst,
  input logic [ADDR_W-1:0]      fetch_addr,
  input logic [2:0][ADDR_W-1:0] cnt_q,
  input logic [2:0]             ph_q,
  input logic [2:0]             scrub_we
);
  logic armed;
  always_ff @(posedge clk) armed <= ~rst;

  // R6
  cnt_sync_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> (cnt_q[0] == cnt_q[1]) && (cnt_q[1] == cnt_q[2]));

  // R5
  phase_toggle_chk: assert property (@(posedge clk) disable iff (rst)
    armed |-> ph_q[0] != $past(ph_q[0]));

  // R5
  we_in_write_phase_chk: assert property (@(posedge clk) disable iff (rst)
    (|scrub_we) |-> ph_q[0]);

  // R7
  no_fetch_clash_chk: assert property (@(posedge clk) disable iff (rst)
    (|scrub_we) |-> cnt_q[0] != fetch_addr);

  // R8
  cnt_step_chk: assert property (@(posedge clk) disable iff (rst)
    (armed && cnt_q[0] != $past(cnt_q[0])) |->
      (cnt_q[0] == ADDR_W'($past(cnt_q[0]) + 1'b1)) && $past(ph_q[0]));
endmodule

bind tmr_irom_scrub tmr_irom_scrub_chk #(.ADDR_W(ADDR_W)) chk_i (
  .clk        (clk),
  .rst        (rst),
  .fetch_addr (fetch_addr),
  .cnt_q      (cnt_q),
  .ph_q       (ph_q),
  .scrub_we   (scrub_we)
);

// File: tb/tmr_irom_scrub_tb_top.sv
`timescale 1ns/1ps
module tmr_irom_scrub_tb_top;
  localparam int AW    = 6;
  localparam int DW    = 16;
  localparam int BW    = 4;
  localparam int DEPTH = 1 << AW;

  logic          clk = 1'b0;
  logic          rst;
  logic [AW-1:0] fetch_addr;
  logic [DW-1:0] instr_out;
  logic          inj_en;
  logic [1:0]    inj_copy;
  logic [AW-1:0] inj_addr;
  logic [BW-1:0] inj_bit;

  int checks = 0;
  int errors = 0;

  always #4 clk = ~clk;

  tmr_irom_scrub #(.ADDR_W(AW), .DATA_W(DW), .BIT_W(BW)) dut_i (
    .clk(clk), .rst(rst), .fetch_addr(fetch_addr), .instr_out(instr_out),
    .inj_en(inj_en), .inj_copy(inj_copy), .inj_addr(inj_addr), .inj_bit(inj_bit));

  function automatic logic [DW-1:0] expect_word(input int a);
    logic [31:0] p;
    p = (32'(a) * 32'h9E37) ^ 32'h5A3C;
    return p[DW-1:0];
  endfunction

  task automatic check(input bit ok, input string req, input logic [DW-1:0] act,
                       input logic [DW-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic fetch_check(input int a, input string req);
    fetch_addr = AW'(a);
    repeat (2) @(negedge clk);
    check(instr_out == expect_word(a), req, instr_out, expect_word(a));
  endtask

  task automatic inject(input int copy, input int a, input int b);
    inj_en = 1'b1; inj_copy = 2'(copy); inj_addr = AW'(a); inj_bit = BW'(b);
    @(negedge clk);
    inj_en = 1'b0;
  endtask

  // stride 5 keeps fetch from chasing the scrub counter
  task automatic sweep(input int off, input string req);
    for (int k = 0; k < DEPTH; k++) fetch_check((k * 5 + off) % DEPTH, req);
  endtask

  task automatic t_reset;
    rst = 1'b1; fetch_addr = '0;
    repeat (3) @(negedge clk);
    check(instr_out == '0, "R2 reset output", instr_out, '0);
    rst = 1'b0;
    @(negedge clk);
    @(negedge clk);
    check(instr_out == expect_word(0), "R1 first fetch", instr_out, expect_word(0));
  endtask

  task automatic t_plain;
    sweep(0, "R1 clean sweep");
    sweep(3, "R1 clean sweep offset");
  endtask

  task automatic t_single_upset;
    inject(0, 10, 3);
    inject(1, 20, 15);
    inject(2, 63, 0);
    fetch_check(10, "R3 copy0 upset");
    fetch_check(20, "R3 copy1 upset");
    fetch_check(63, "R3 copy2 upset");
    sweep(1, "R3 sweep with upsets");
  endtask

  task automatic t_scrub_restore;
    repeat (3) sweep(2, "R1 during scrub");
    inject(1, 10, 3);
    inject(2, 20, 15);
    inject(0, 63, 0);
    fetch_check(10, "R4 restored addr10");
    fetch_check(20, "R4 restored addr20");
    fetch_check(63, "R4 restored addr63");
    repeat (3) sweep(4, "R4 after second upsets");
  endtask

  task automatic t_wrap;
    inject(0, DEPTH - 1, 7);
    inject(0, 0, 7);
    repeat (3) sweep(1, "R8 waiting pass");
    inject(2, DEPTH - 1, 7);
    inject(2, 0, 7);
    fetch_check(DEPTH - 1, "R8 last location scrubbed");
    fetch_check(0, "R8 first location scrubbed");
    repeat (3) sweep(0, "R8 cleanup pass");
  endtask

  task automatic t_copy_code;
    inject(3, 5, 2);
    inject(0, 5, 2);
    fetch_check(5, "R9 copy code 3 touches nothing");
    inject(0, 6, 9);
    inject(1, 6, 9);
    fetch_address_corrupt(6, 9, "R9 two copies hit");
  endtask

  task automatic fetch_address_corrupt(input int a, input int b, input string req);
    logic [DW-1:0] e;
    e = expect_word(a) ^ (DW'(1) << b);
    fetch_addr = AW'(a);
    repeat (2) @(negedge clk);
    check(instr_out == e, req, instr_out, e);
  endtask

  // parked fetch blocks scrubbing of that word, so a second hit must show
  task automatic t_park;
    fetch_addr = AW'(33);
    repeat (300) @(negedge clk);
    inject(0, 33, 4);
    repeat (300) @(negedge clk);
    check(instr_out == expect_word(33), "R7 parked single upset",
          instr_out, expect_word(33));
    inject(1, 33, 4);
    repeat (2) @(negedge clk);
    check(instr_out == (expect_word(33) ^ 16'h0010), "R7 clash write held",
          instr_out, expect_word(33) ^ 16'h0010);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    inj_en = 1'b0; inj_copy = '0; inj_addr = '0; inj_bit = '0;
    rst = 1'b1; fetch_addr = '0;
    @(negedge clk);
    t_reset();
    t_plain();
    t_single_upset();
    t_scrub_restore();
    t_wrap();
    t_copy_code();
    t_park();
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule